// File: doc/BRIEF.md
# Host interrupt mask and status controller

This block collects single-cycle event pulses from up to 22 sources inside a wireless MAC and turns them into one level-sensitive interrupt line for a host processor. Each implemented source owns a sticky pending bit. The host reads the pending bits without side effects and retires them by writing ones to an acknowledge offset. A per-source mask decides which pending bits may raise the interrupt line.

The mask is active-high: a 1 blocks its source. The host can write the mask as a whole word. It can also flip single bits atomically through a write-one-to-set offset and a write-one-to-clear offset, so that no read-modify-write sequence is needed. The host side is a plain synchronous register bus with address, write enable, write data, read enable and read data.

Implemented source positions are bits 0 to 10, 14, 16 and 17. The source meanings are:
- bit 0: receive buffer 0
- bit 1: transmit data
- bit 2: transmit transfer
- bit 3: receive buffer 1
- bit 4: receive transfer
- bits 5 and 6: mailbox events A and B
- bit 7: host wake
- bits 8 and 9: trace events A and B
- bit 10: command done
- bit 14: init done
- bits 16 and 17: coexistence sense on and sense off

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset, the mask reads 0x00000001 so that only source 0 is blocked. The pending bits read 0 and `host_irq` is 0.
- R2: A mask bit at 1 keeps its pending source from raising `host_irq`. A mask bit at 0 lets it through.
- R3: A write to offset 0x4E0 sets every mask bit whose write-data bit is 1. Only write-data bits 15:0 count. Bits written as 0 leave the mask unchanged.
- R4: A write to offset 0x4E4 clears every mask bit whose write-data bit is 1. Only write-data bits 15:0 count. Bits written as 0 leave the mask unchanged.
- R5: `host_irq` is a register. It equals the OR of (pending AND NOT mask) as that value stood one clock earlier. It rises on the second rising edge after an unmasked pulse is sampled.
- R6: Offset 0x4DC reads and writes the whole mask word directly.
- R7: A read of offset 0x4E8 returns the pending bits and clears none of them.
- R8: A pending bit is set by its source pulse. It stays set until the host writes a 1 to its position at offset 0x4EC.
- R9: If a source pulse and an acknowledge of the same bit occur in one cycle, the pending bit stays set.
- R10: Positions outside bits 0 to 10, 14, 16 and 17 always read 0. Writes and pulses on those positions are ignored. Offsets 0x4E0, 0x4E4 and 0x4EC read as 0.
- R11: `bus_rdata` is loaded on the clock edge that samples `bus_read`. It is valid from then on. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 22 | One-cycle event pulses, one per source |
| bus_addr | input | 12 | Register offset |
| bus_write | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_read | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The bench drives a pulse and an acknowledge of the same bit in one cycle. A design that let the clear win would lose that event, and the status would read 0 instead of the source bit. It writes the set and clear offsets with ones above bit 15. A design that honoured those bits would change the coexistence mask bits. It writes all ones directly to the mask and pulses all 22 sources, so any reserved position stored in a register shows up as a nonzero bit on readback. It also reads the status twice in a row and requires the same value both times, which catches a read that clears the pending bits.

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int SRC_N    = 22,
  parameter int SETCLR_W = 16,
  parameter logic [SRC_N-1:0]  SRC_VALID = 22'h0347FF,
  parameter logic [SRC_N-1:0]  MASK_RST  = 22'h000001,
  parameter logic [ADDR_W-1:0] OFS_MASK  = 12'h4DC,
  parameter logic [ADDR_W-1:0] OFS_MSET  = 12'h4E0,
  parameter logic [ADDR_W-1:0] OFS_MCLR  = 12'h4E4,
  parameter logic [ADDR_W-1:0] OFS_STAT  = 12'h4E8,
  parameter logic [ADDR_W-1:0] OFS_ACK   = 12'h4EC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_pulse,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_read,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              host_irq
);
  localparam logic [SRC_N-1:0] SC_VALID =
    SRC_VALID & SRC_N'((64'd1 << SETCLR_W) - 64'd1);

  logic [SRC_N-1:0] mask_q, pend_q, wsrc, set_bits, clr_bits, ack_bits;
  logic             wr_mask;
  logic             unused_hi;

  assign wsrc      = bus_wdata[SRC_N-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:SRC_N];
  assign wr_mask   = bus_write && (bus_addr == OFS_MASK);
  assign set_bits  = (bus_write && bus_addr == OFS_MSET) ? (wsrc & SC_VALID) : '0;
  assign clr_bits  = (bus_write && bus_addr == OFS_MCLR) ? (wsrc & SC_VALID) : '0;
  assign ack_bits  = (bus_write && bus_addr == OFS_ACK)  ? wsrc : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= MASK_RST & SRC_VALID;
    else if (wr_mask) mask_q <= wsrc & SRC_VALID;
    else              mask_q <= (mask_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack_bits) | (src_pulse & SRC_VALID);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_irq <= 1'b0;
    else        host_irq <= |(pend_q & ~mask_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_read) begin
      if (bus_addr == OFS_MASK)      bus_rdata <= DATA_W'(mask_q);
      else if (bus_addr == OFS_STAT) bus_rdata <= DATA_W'(pend_q);
      else                           bus_rdata <= '0;
    end
  end
endmodule

module host_irq_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SRC_N  = 22,
  parameter logic [SRC_N-1:0]  SRC_VALID = 22'h0347FF,
  parameter logic [SRC_N-1:0]  SC_VALID  = 22'h0047FF,
  parameter logic [ADDR_W-1:0] OFS_MSET  = 12'h4E0,
  parameter logic [ADDR_W-1:0] OFS_MCLR  = 12'h4E4,
  parameter logic [ADDR_W-1:0] OFS_ACK   = 12'h4EC
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  src_pulse,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [SRC_N-1:0]  mask_q,
  input logic [SRC_N-1:0]  pend_q,
  input logic              host_irq
);
  logic [SRC_N-1:0] w, ackv;
  assign w    = bus_wdata[SRC_N-1:0];
  assign ackv = (bus_write && bus_addr == OFS_ACK) ? w : '0;

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_addr == OFS_MSET) |=>
      ((mask_q & $past(w & SC_VALID)) == $past(w & SC_VALID)));

  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_addr == OFS_MCLR) |=> ((mask_q & $past(w & SC_VALID)) == '0));

  assert_irq_registered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == $past(|(pend_q & ~mask_q)));

  assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~ackv)) == $past(pend_q & ~ackv)));

  assert_pulse_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(src_pulse & SRC_VALID)) == $past(src_pulse & SRC_VALID)));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q | mask_q) & ~SRC_VALID) == '0);
endmodule

bind host_irq_ctrl host_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_N(SRC_N), .SRC_VALID(SRC_VALID),
  .SC_VALID(SC_VALID), .OFS_MSET(OFS_MSET), .OFS_MCLR(OFS_MCLR), .OFS_ACK(OFS_ACK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_addr(bus_addr),
  .bus_write(bus_write), .bus_wdata(bus_wdata), .mask_q(mask_q),
  .pend_q(pend_q), .host_irq(host_irq)
);

// File: tb/host_irq_ctrl_tb.sv
`timescale 1ns/1ps
module host_irq_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [21:0] src_pulse = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_write = 0, bus_read = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        host_irq;
  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_flag = 0;
  bit          done = 0;

  localparam logic [11:0] A_MASK = 12'h4DC, A_SET = 12'h4E0, A_CLR = 12'h4E4,
                          A_STAT = 12'h4E8, A_ACK = 12'h4EC;

  always #5 clk = ~clk;

  host_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_read(bus_read), .bus_rdata(bus_rdata), .host_irq(host_irq));

  always @(posedge clk) rd_flag <= bus_read;

  always @(negedge clk) if (rd_flag && exp_q.size() > 0) begin
    logic [31:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s: rdata got %h expected %h", t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_read = 1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_read = 0;
  endtask

  task automatic pulse(input logic [21:0] p);
    @(negedge clk); src_pulse = p;
    @(negedge clk); src_pulse = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (host_irq !== e) begin
      fails++;
      $display("FAIL %s: host_irq got %0b expected %0b", t, host_irq, e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk_irq(0, "R1 irq after reset");
    rd(A_MASK, 32'h1, "R1 mask reset");
    rd(A_STAT, 32'h0, "R1 pending reset");
    pulse(22'h1);
    chk_irq(0, "R2 masked source 0");
    rd(A_STAT, 32'h1, "R7 status read");
    rd(A_STAT, 32'h1, "R7 second status read unchanged");
    wr(A_CLR, 32'h1);
    chk_irq(1, "R4 R5 unmask raises irq");
    rd(A_MASK, 32'h0, "R4 clear port");
    wr(A_SET, 32'h0003_0001);
    rd(A_MASK, 32'h1, "R3 R10 set port upper bits ignored");
    chk_irq(0, "R2 remasked");
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h0003_47FF, "R6 R10 direct mask write");
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h0003_0000, "R4 R10 clear keeps bits 17:16");
    wr(A_MASK, 32'h0);
    chk_irq(1, "R2 unmasked pending");
    wr(A_ACK, 32'h1);
    chk_irq(0, "R8 ack drops irq");
    rd(A_STAT, 32'h0, "R8 ack clears pending");
    pulse(22'h3F_FFFF);
    rd(A_STAT, 32'h0003_47FF, "R10 reserved sources ignored");
    chk_irq(1, "R5 all sources");
    @(negedge clk); bus_write = 1; bus_addr = A_ACK; bus_wdata = 32'hFFFF_FFFF;
    src_pulse = 22'h8;
    @(negedge clk); bus_write = 0; src_pulse = '0;
    rd(A_STAT, 32'h8, "R9 pulse beats ack");
    wr(A_SET, 32'h8);
    chk_irq(0, "R2 R3 source 3 masked");
    wr(A_CLR, 32'h0);
    rd(A_MASK, 32'h8, "R4 zero write no effect");
    rd(A_SET, 32'h0, "R10 set port reads 0");
    rd(A_ACK, 32'h0, "R10 ack port reads 0");
    rd(12'h100, 32'h0, "R11 unmapped offset");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    if (exp_q.size() != 0) begin
      fails++; checks++;
      $display("FAIL R11: reads got %0d pending expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule